// File: doc/BRIEF.md
# NAND Single-Bit ECC Checker

This block protects one 512-byte NAND data region with a 24-bit Hamming check code. As data bytes stream past it, an accumulator builds a raw 32-bit parity word. The word is packed to 24 bits and inverted, so that an erased region (all bytes 0xFF) yields an all-ones code, which is exactly what an erased spare area reads back. The packed code goes out as three bytes, least significant byte first, ready to be written to the spare area.

On a read, the host streams the region through the accumulator, then presents the code read from the spare area and pulses `check`. One cycle later the block reports one of four outcomes. The data may be clean. It may hold a single flipped data bit, in which case the block gives the byte offset and bit index to flip back. The flip may lie in the stored code itself. Or the damage may be uncorrectable. The block never touches the data buffer. Correction is left to the owner of the page buffer. `REGION_BYTES` may be lowered below 512 to cover a shorter region. Offsets that decode at or beyond that size are then refused.

Top module: `nand_ecc1_checker`

## Requirements
- R1: After reset, and in the cycle after a `start` pulse, `raw_parity` is 0, `calc_code` is 24'hFFFFFF and `acc_done` is low.
- R2: Each cycle with `in_valid` high and `acc_done` low accepts `in_byte` at the next byte offset, starting at 0. `acc_done` rises once `REGION_BYTES` bytes have been taken. After that, further bytes leave `raw_parity` unchanged until the next `start`.
- R3: Data bit b of the byte at offset a has position p = a*8 + b (12 bits). `raw_parity[16+k]` is the XOR of every accepted data bit whose p has bit k set. `raw_parity[k]` is the XOR of those whose p has bit k clear. Bits 31:28 and 15:12 are always 0.
- R4: `calc_code` = ~{raw_parity[27:16], raw_parity[11:0]}, with byte 0 of the stored form in bits 7:0. An all-0xFF region gives 24'hFFFFFF.
- R5: A `check` pulse samples `stored_code` and the current accumulator. `res_valid` is high exactly in the following cycle. `res_status` is encoded 0 = clean, 1 = data bit corrected, 2 = error in the stored code, 3 = uncorrectable.
- R6: With d = `calc_code` XOR `stored_code`, a zero d gives status 0.
- R7: When d[23:12] XOR d[11:0] equals 12'hFFF and d[23:15] < `REGION_BYTES`, the status is 1, `res_byte` = d[23:15] and `res_bit` = d[14:12].
- R8: When d[23:12] XOR d[11:0] equals 12'hFFF but d[23:15] >= `REGION_BYTES`, the status is 3.
- R9: When exactly one bit of d is set, the status is 2.
- R10: Every other non-zero d gives status 3. This includes any two flipped data bits.
- R11: When `res_valid` is high and the status is not 1, `res_byte` and `res_bit` are 0.
- R12: `start` takes priority over `in_valid` in the same cycle. That byte is discarded, and the next accepted byte lands at offset 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Clears the accumulator and the byte count |
| in_valid | input | 1 | `in_byte` carries a region byte this cycle |
| in_byte | input | 8 | Region data byte |
| acc_done | output | 1 | All region bytes have been accumulated |
| raw_parity | output | 32 | Raw parity word |
| calc_code | output | 24 | Packed, inverted code (byte 0 in bits 7:0) |
| check | input | 1 | Compare request |
| stored_code | input | 24 | Code read from the spare area |
| res_valid | output | 1 | Result strobe, one cycle |
| res_status | output | 2 | Outcome code |
| res_byte | output | 9 | Byte offset to correct |
| res_bit | output | 3 | Bit index to correct |

## Verification
A wrong byte counter shifts every later byte's address parity. It therefore shows up in `raw_parity` as soon as the region has been streamed, and in the very next check as a false outcome. A stuck or mis-steered accumulator bit breaks the all-ones erased code and turns every clean read into a single-bit "code error". A classifier that orders its tests wrongly surfaces one cycle after `check`, as a wrong status or a non-zero location. The bench therefore compares the parity word after every stream. It also drives single, double and code-side flips, plus a shortened region, to separate the offset bound from the code-error path.

// File: rtl/nand_ecc1_pkg.sv
package nand_ecc1_pkg;

  localparam int HALF_W = 12;
  localparam int CODE_W = 2 * HALF_W;
  localparam int OFFS_W = 9;

  typedef enum logic [1:0] {
    ST_CLEAN    = 2'd0,
    ST_FIXED    = 2'd1,
    ST_CODE_ERR = 2'd2,
    ST_UNCORR   = 2'd3
  } ecc_status_e;

  typedef struct packed {
    ecc_status_e       status;
    logic [OFFS_W-1:0] offs;
    logic [2:0]        bidx;
  } ecc_verdict_t;

  // Fold one byte at a given offset into the raw parity word.
  function automatic logic [31:0] raw_step(input logic [31:0] raw,
                                           input logic [OFFS_W-1:0] offs,
                                           input logic [7:0] data);
    logic [HALF_W-1:0] hi, lo;
    logic              px;
    hi = raw[27:16];
    lo = raw[11:0];
    px = ^data;
    for (int k = 0; k < 3; k++) begin
      for (int b = 0; b < 8; b++) begin
        if (b[k]) hi[k] = hi[k] ^ data[b];
        else      lo[k] = lo[k] ^ data[b];
      end
    end
    for (int k = 3; k < HALF_W; k++) begin
      if (offs[k-3]) hi[k] = hi[k] ^ px;
      else           lo[k] = lo[k] ^ px;
    end
    return {4'b0, hi, 4'b0, lo};
  endfunction

  // Drop the reserved nibbles and invert.
  function automatic logic [CODE_W-1:0] pack_code(input logic [31:0] raw);
    return ~{raw[27:16], raw[11:0]};
  endfunction

  function automatic ecc_verdict_t classify(input logic [CODE_W-1:0] diff,
                                            input int region);
    ecc_verdict_t v;
    v = '{status: ST_CLEAN, offs: '0, bidx: '0};
    if (diff == '0) begin
      v.status = ST_CLEAN;
    end else if ((diff[23:12] ^ diff[11:0]) == 12'hFFF) begin
      if (int'(diff[23:15]) < region) begin
        v.status = ST_FIXED;
        v.offs   = diff[23:15];
        v.bidx   = diff[14:12];
      end else begin
        v.status = ST_UNCORR;
      end
    end else if ((diff & (diff - 24'd1)) == '0) begin
      v.status = ST_CODE_ERR;
    end else begin
      v.status = ST_UNCORR;
    end
    return v;
  endfunction

endpackage

// File: rtl/nand_ecc1_parity_acc.sv
module nand_ecc1_parity_acc
  import nand_ecc1_pkg::*;
#(
  parameter int REGION_BYTES = 512
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        in_valid,
  input  logic [7:0]  in_byte,
  output logic [31:0] raw_parity,
  output logic        acc_done,
  output logic        take
);
  localparam int CNT_W = $clog2(REGION_BYTES + 1);

  logic [CNT_W-1:0] cnt_q;
  logic [31:0]      raw_q;

  assign acc_done   = (cnt_q == CNT_W'(REGION_BYTES));
  assign take       = in_valid && !start && !acc_done;
  assign raw_parity = raw_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      raw_q <= '0;
    end else if (start) begin
      cnt_q <= '0;
      raw_q <= '0;
    end else if (take) begin
      cnt_q <= cnt_q + CNT_W'(1);
      raw_q <= raw_step(raw_q, OFFS_W'(cnt_q), in_byte);
    end
  end
endmodule

// File: rtl/nand_ecc1_compare.sv
module nand_ecc1_compare
  import nand_ecc1_pkg::*;
#(
  parameter int REGION_BYTES = 512
) (
  input  logic [CODE_W-1:0] calc_code,
  input  logic [CODE_W-1:0] stored_code,
  output logic [CODE_W-1:0] diff,
  output ecc_verdict_t      verdict
);
  assign diff    = calc_code ^ stored_code;
  assign verdict = classify(diff, REGION_BYTES);
endmodule

// File: rtl/nand_ecc1_result_reg.sv
module nand_ecc1_result_reg
  import nand_ecc1_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              check,
  input  ecc_verdict_t      verdict,
  output logic              res_valid,
  output logic [1:0]        res_status,
  output logic [OFFS_W-1:0] res_byte,
  output logic [2:0]        res_bit
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid  <= 1'b0;
      res_status <= '0;
      res_byte   <= '0;
      res_bit    <= '0;
    end else begin
      res_valid <= check;
      if (check) begin
        res_status <= verdict.status;
        res_byte   <= verdict.offs;
        res_bit    <= verdict.bidx;
      end
    end
  end
endmodule

// File: rtl/nand_ecc1_checker.sv
module nand_ecc1_checker
  import nand_ecc1_pkg::*;
#(
  parameter int REGION_BYTES = 512
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        in_valid,
  input  logic [7:0]  in_byte,
  output logic        acc_done,
  output logic [31:0] raw_parity,
  output logic [23:0] calc_code,
  input  logic        check,
  input  logic [23:0] stored_code,
  output logic        res_valid,
  output logic [1:0]  res_status,
  output logic [8:0]  res_byte,
  output logic [2:0]  res_bit
);
  logic              take_w;
  logic [CODE_W-1:0] diff_w;
  ecc_verdict_t      verdict_w;

  nand_ecc1_parity_acc #(.REGION_BYTES(REGION_BYTES)) u_acc (
    .clk(clk), .rst_n(rst_n), .start(start), .in_valid(in_valid),
    .in_byte(in_byte), .raw_parity(raw_parity), .acc_done(acc_done),
    .take(take_w)
  );

  assign calc_code = pack_code(raw_parity);

  nand_ecc1_compare #(.REGION_BYTES(REGION_BYTES)) u_cmp (
    .calc_code(calc_code), .stored_code(stored_code),
    .diff(diff_w), .verdict(verdict_w)
  );

  nand_ecc1_result_reg u_res (
    .clk(clk), .rst_n(rst_n), .check(check), .verdict(verdict_w),
    .res_valid(res_valid), .res_status(res_status),
    .res_byte(res_byte), .res_bit(res_bit)
  );
endmodule

// File: rtl/nand_ecc1_checker_sva.sv
module nand_ecc1_checker_sva #(
  parameter int REGION_BYTES = 512
) (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        check,
  input logic        take_w,
  input logic        acc_done,
  input logic [31:0] raw_parity,
  input logic [23:0] diff_w,
  input logic        res_valid,
  input logic [1:0]  res_status,
  input logic [8:0]  res_byte,
  input logic [2:0]  res_bit
);
  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (raw_parity == 32'd0 && !acc_done)); // R1

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_done && !start) |=> acc_done); // R2

  AST_NO_TAKE_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_done && !start) |=> $stable(raw_parity)); // R2

  AST_START_BEATS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !take_w); // R12

  AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    take_w |=> (raw_parity[31:28] == 4'd0 && raw_parity[15:12] == 4'd0)); // R3

  AST_RESULT_FOLLOWS_CHECK: assert property (@(posedge clk) disable iff (!rst_n)
    check |=> res_valid); // R5

  AST_RESULT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    !check |=> !res_valid); // R5

  AST_CLEAN_MEANS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_status == 2'd0) |-> ($past(diff_w) == 24'd0)); // R6

  AST_FIXED_IN_REGION: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_status == 2'd1) |-> (int'(res_byte) < REGION_BYTES)); // R8

  AST_CODE_ERR_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_status == 2'd2) |-> ($countones($past(diff_w)) == 1)); // R9

  AST_LOC_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_status != 2'd1) |-> (res_byte == 9'd0 && res_bit == 3'd0)); // R11
endmodule

bind nand_ecc1_checker nand_ecc1_checker_sva #(.REGION_BYTES(REGION_BYTES)) u_sva (
  .clk(clk), .rst_n(rst_n), .start(start), .check(check), .take_w(take_w),
  .acc_done(acc_done), .raw_parity(raw_parity), .diff_w(diff_w),
  .res_valid(res_valid), .res_status(res_status), .res_byte(res_byte),
  .res_bit(res_bit)
);

// File: tb/nand_ecc1_checker_test.sv
module nand_ecc1_checker_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, in_valid = 1'b0, check = 1'b0, check_s = 1'b0;
  logic [7:0]  in_byte = 8'd0;
  logic [23:0] stored = 24'd0, stored_s = 24'd0;
  logic        acc_done, acc_done_s, res_valid, res_valid_s;
  logic [31:0] raw_parity, raw_parity_s;
  logic [23:0] calc_code, calc_code_s;
  logic [1:0]  res_status, res_status_s;
  logic [8:0]  res_byte, res_byte_s;
  logic [2:0]  res_bit, res_bit_s;

  int n_chk = 0, n_fail = 0;
  logic [7:0] page [512];

  always #10 clk = ~clk;

  nand_ecc1_checker uut (
    .clk(clk), .rst_n(rst_n), .start(start), .in_valid(in_valid), .in_byte(in_byte),
    .acc_done(acc_done), .raw_parity(raw_parity), .calc_code(calc_code),
    .check(check), .stored_code(stored), .res_valid(res_valid),
    .res_status(res_status), .res_byte(res_byte), .res_bit(res_bit));

  nand_ecc1_checker #(.REGION_BYTES(384)) uut_r384 (
    .clk(clk), .rst_n(rst_n), .start(start), .in_valid(in_valid), .in_byte(in_byte),
    .acc_done(acc_done_s), .raw_parity(raw_parity_s), .calc_code(calc_code_s),
    .check(check_s), .stored_code(stored_s), .res_valid(res_valid_s),
    .res_status(res_status_s), .res_byte(res_byte_s), .res_bit(res_bit_s));

  typedef struct packed {
    logic [1:0] mode;   // equals expected status: 0 clean,1 data flip,2 code flip,3 double flip
    logic [8:0] a;
    logic [2:0] b;
    logic [8:0] a2;
    logic [2:0] b2;
    logic [4:0] cbit;
    logic [7:0] seed;
  } vec_t;

  localparam int NVEC = 10;
  localparam vec_t VECS [NVEC] = '{
    '{2'd0, 9'd0,   3'd0, 9'd0,   3'd0, 5'd0,  8'd3},
    '{2'd1, 9'd0,   3'd0, 9'd0,   3'd0, 5'd0,  8'd5},
    '{2'd1, 9'd511, 3'd7, 9'd0,   3'd0, 5'd0,  8'd7},
    '{2'd1, 9'd256, 3'd4, 9'd0,   3'd0, 5'd0,  8'd11},
    '{2'd1, 9'd73,  3'd2, 9'd0,   3'd0, 5'd0,  8'd13},
    '{2'd2, 9'd0,   3'd0, 9'd0,   3'd0, 5'd0,  8'd17},
    '{2'd2, 9'd0,   3'd0, 9'd0,   3'd0, 5'd23, 8'd19},
    '{2'd2, 9'd0,   3'd0, 9'd0,   3'd0, 5'd12, 8'd23},
    '{2'd3, 9'd10,  3'd1, 9'd10,  3'd6, 5'd0,  8'd29},
    '{2'd3, 9'd0,   3'd0, 9'd300, 3'd5, 5'd0,  8'd31}
  };

  task automatic expect_eq(input string req, input string what,
                           input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // Bit-serial reference: each set bit at position p toggles p into the
  // upper half and ~p into the lower half.
  function automatic logic [31:0] model_raw(input int nbytes);
    logic [11:0] hi = 12'd0, lo = 12'd0;
    for (int i = 0; i < nbytes; i++)
      for (int b = 0; b < 8; b++)
        if (page[i][b]) begin
          hi = hi ^ 12'(i * 8 + b);
          lo = lo ^ ~12'(i * 8 + b);
        end
    return {4'd0, hi, 4'd0, lo};
  endfunction

  function automatic logic [23:0] code_of(input logic [31:0] raw);
    return ~{raw[27:16], raw[11:0]};
  endfunction

  function automatic logic [23:0] flip_sig(input int a, input int b);
    return {12'(a * 8 + b), ~12'(a * 8 + b)};
  endfunction

  task automatic fill(input int seed);
    for (int i = 0; i < 512; i++) page[i] = 8'((i * seed) ^ (i >> 2) ^ 8'h5A);
  endtask

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic stream(input int first, input int last);
    for (int i = first; i < last; i++) begin
      @(negedge clk) in_valid = 1'b1; in_byte = page[i];
    end
    @(negedge clk) in_valid = 1'b0;
  endtask

  task automatic do_check(input logic [23:0] code, input logic [23:0] code_s);
    @(negedge clk) check = 1'b1; check_s = 1'b1; stored = code; stored_s = code_s;
    @(negedge clk) check = 1'b0; check_s = 1'b0;
  endtask

  initial begin
    logic [31:0] raw_clean;
    logic [23:0] stored_v;
    vec_t v;

    repeat (3) @(negedge clk);
    // R1 / R5: reset state
    expect_eq("R1", "reset raw_parity", raw_parity, 32'd0);
    expect_eq("R1", "reset calc_code", {8'd0, calc_code}, 32'hFFFFFF);
    expect_eq("R1", "reset acc_done", {31'd0, acc_done}, 32'd0);
    expect_eq("R5", "reset res_valid", {31'd0, res_valid}, 32'd0);
    rst_n = 1'b1;

    // Table walk: R3 R6 R7 R9 R10 R11
    for (int n = 0; n < NVEC; n++) begin
      v = VECS[n];
      fill(int'(v.seed));
      raw_clean = model_raw(512);
      stored_v  = code_of(raw_clean);
      if (v.mode == 2'd2) stored_v = stored_v ^ (24'd1 << v.cbit);
      if (v.mode == 2'd1 || v.mode == 2'd3) page[v.a][v.b] = ~page[v.a][v.b];
      if (v.mode == 2'd3) page[v.a2][v.b2] = ~page[v.a2][v.b2];
      pulse_start();
      stream(0, 512);
      expect_eq("R3", $sformatf("vec %0d raw_parity", n), raw_parity, model_raw(512));
      expect_eq("R4", $sformatf("vec %0d calc_code", n), {8'd0, calc_code},
                {8'd0, code_of(model_raw(512))});
      do_check(stored_v, 24'd0);
      expect_eq("R5", $sformatf("vec %0d res_valid", n), {31'd0, res_valid}, 32'd1);
      expect_eq(v.mode == 2'd0 ? "R6" : v.mode == 2'd1 ? "R7" :
                v.mode == 2'd2 ? "R9" : "R10",
                $sformatf("vec %0d status", n), {30'd0, res_status}, {30'd0, v.mode});
      expect_eq(v.mode == 2'd1 ? "R7" : "R11", $sformatf("vec %0d byte", n),
                {23'd0, res_byte}, v.mode == 2'd1 ? {23'd0, v.a} : 32'd0);
      expect_eq(v.mode == 2'd1 ? "R7" : "R11", $sformatf("vec %0d bit", n),
                {29'd0, res_bit}, v.mode == 2'd1 ? {29'd0, v.b} : 32'd0);
    end

    // R5: result strobe lasts one cycle
    @(negedge clk);
    expect_eq("R5", "res_valid drops", {31'd0, res_valid}, 32'd0);

    // R4: erased region checks clean
    for (int i = 0; i < 512; i++) page[i] = 8'hFF;
    pulse_start();
    stream(0, 512);
    expect_eq("R4", "erased calc_code", {8'd0, calc_code}, 32'hFFFFFF);
    do_check(24'hFFFFFF, 24'hFFFFFF);
    expect_eq("R4", "erased status", {30'd0, res_status}, 32'd0);

    // R2: done exactly at the region size, extra bytes ignored
    fill(41);
    pulse_start();
    expect_eq("R1", "start clears raw", raw_parity, 32'd0);
    stream(0, 511);
    expect_eq("R2", "done low at 511", {31'd0, acc_done}, 32'd0);
    stream(511, 512);
    expect_eq("R2", "done high at 512", {31'd0, acc_done}, 32'd1);
    raw_clean = model_raw(512);
    for (int i = 0; i < 512; i++) page[i] = 8'(i + 1);
    stream(0, 6);
    expect_eq("R2", "extra bytes ignored", raw_parity, raw_clean);

    // R12: start wins over in_valid, next byte lands at offset 0
    @(negedge clk) start = 1'b1; in_valid = 1'b1; in_byte = 8'hA5;
    @(negedge clk) start = 1'b0; in_valid = 1'b0;
    expect_eq("R12", "start beats data", raw_parity, 32'd0);
    @(negedge clk) in_valid = 1'b1; in_byte = 8'h01;
    @(negedge clk) in_valid = 1'b0;
    expect_eq("R12", "first byte at offset 0", raw_parity, 32'h00000FFF);

    // R8: shortened region refuses offsets at or past its size
    fill(43);
    pulse_start();
    stream(0, 512);
    expect_eq("R2", "short region done", {31'd0, acc_done_s}, 32'd1);
    expect_eq("R3", "short region raw", raw_parity_s, model_raw(384));
    do_check(code_of(model_raw(512)) ^ flip_sig(400, 3),
             code_of(model_raw(384)) ^ flip_sig(400, 3));
    expect_eq("R8", "offset 400 short status", {30'd0, res_status_s}, 32'd3);
    expect_eq("R11", "offset 400 short byte", {23'd0, res_byte_s}, 32'd0);
    expect_eq("R7", "offset 400 full status", {30'd0, res_status}, 32'd1);
    expect_eq("R7", "offset 400 full byte", {23'd0, res_byte}, 32'd400);
    do_check(24'd0, code_of(model_raw(384)) ^ flip_sig(383, 7));
    expect_eq("R8", "offset 383 short status", {30'd0, res_status_s}, 32'd1);
    expect_eq("R8", "offset 383 short byte", {23'd0, res_byte_s}, 32'd383);
    expect_eq("R8", "offset 383 short bit", {29'd0, res_bit_s}, 32'd7);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule